// File: doc/BRIEF.md
# Fixed-Priority Interrupt Arbiter

This block keeps one pending flag for each of fourteen asynchronous interrupt sources. Timers, external pins and doorbell logic raise a flag with a one-cycle set pulse. Whenever no delivery is outstanding, the arbiter masks the pending flags with the current machine-state enables. It then picks the eligible source of highest priority and presents its code to the exception-entry logic as a registered value with a valid strobe.

The delivery is held until the consumer acknowledges it. One idle cycle follows, and then the next evaluation runs. Most sources lose their pending flag when they are picked. The external and critical-external sources can be configured as level-sensitive, in which case their flags survive delivery until the input side stops requesting.

Top module: `irq_arb_top`

## Requirements
- R1: Sources are ranked, highest first, and each is coded by its rank: 0 reset, 1 machine check, 2 debug, 3 hypervisor decrementer, 4 critical external, 5 watchdog, 6 critical doorbell, 7 fixed-interval timer, 8 programmable-interval timer, 9 decrementer, 10 external, 11 doorbell, 12 performance monitor, 13 thermal. Bit k of `req_set` sets source k. When several sources are eligible, `irq_code` carries the one with the lowest code.
- R2: After a synchronous reset, `irq_valid` is low, `irq_code` is 0 and no source is pending.
- R3: Machine check (code 1) is delivered only while `msr_me` is 1.
- R4: The hypervisor decrementer (code 3) is delivered only while `hdec_ctl_en` is 1 and at least one of the following holds: `msr_ee` is 1, `msr_hv` is 0, or `msr_pr` is 1.
- R5: Codes 4, 5 and 6 are delivered only while `msr_ce` is 1. Codes 0 and 2 are never masked.
- R6: Codes 7 to 13 are delivered only while `msr_ee` is 1.
- R7: Delivering any source other than codes 4 and 10 clears its pending flag, so it is delivered once per set pulse.
- R8: Code 10 keeps its pending flag after delivery while `ext_edge_mode` is 0, and has it cleared while that input is 1. Code 4 behaves the same way under `crit_edge_mode`.
- R9: A set pulse that arrives in the same cycle as the clear caused by a delivery of that source wins, so the source stays pending.
- R10: `irq_valid` rises two clock edges after a set pulse for an eligible source, given that no delivery is outstanding. While `take_ack` is low it holds high with a stable `irq_code`. It falls on the edge that samples `take_ack` high, and the next evaluation occurs on the edge after that.
- R11: A source that is pending while masked stays pending. It is delivered one edge after its enable rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_set | input | 14 | One-cycle set pulses, bit k for source code k |
| msr_me | input | 1 | Machine-check enable |
| msr_ce | input | 1 | Critical-interrupt enable |
| msr_ee | input | 1 | External (normal group) enable |
| msr_hv | input | 1 | Hypervisor mode |
| msr_pr | input | 1 | Problem state |
| hdec_ctl_en | input | 1 | Hypervisor-decrementer enable control bit |
| ext_edge_mode | input | 1 | 1: external source cleared on delivery |
| crit_edge_mode | input | 1 | 1: critical-external source cleared on delivery |
| take_ack | input | 1 | Consumer accepts the presented delivery |
| irq_valid | output | 1 | A delivery is presented |
| irq_code | output | 4 | Code of the delivered source |

## Verification
A pending flag that is wrongly lost shows up as a delivery that never appears after the ack, within two edges. A flag that is wrongly kept shows up as a repeated delivery two edges after the ack. A broken gate or priority term shows as a wrong or missing code on the very edge where the first delivery is due. The bench therefore checks each trial at the exact edge where a delivery should appear, and again at the edge after each ack.

// File: rtl/irq_arb_pkg.sv
// Shared constants for the interrupt arbiter: source count, code width and
// the rank of each source (rank doubles as the delivered code).
package irq_arb_pkg;
    localparam int NUM_SRC   = 14;
    localparam int CODE_W    = $clog2(NUM_SRC);

    localparam int SRC_RESET = 0;
    localparam int SRC_MCHK  = 1;
    localparam int SRC_DBG   = 2;
    localparam int SRC_HDEC  = 3;
    localparam int SRC_CEXT  = 4;
    localparam int SRC_WDOG  = 5;
    localparam int SRC_CDB   = 6;
    localparam int SRC_FIT   = 7;
    localparam int SRC_PIT   = 8;
    localparam int SRC_DEC   = 9;
    localparam int SRC_EXT   = 10;
    localparam int SRC_DB    = 11;
    localparam int SRC_PERF  = 12;
    localparam int SRC_THERM = 13;
endpackage

// File: rtl/irq_arb_gate.sv
// Enable-mask builder.
// Produces one enable bit per source from the machine-state inputs, plus a
// keep mask naming the sources whose pending flag must survive delivery.
// Assumes the source ranks of irq_arb_pkg.
module irq_arb_gate
    import irq_arb_pkg::*;
#(
    parameter int N_SRC = NUM_SRC
) (
    input  logic             msr_me,
    input  logic             msr_ce,
    input  logic             msr_ee,
    input  logic             msr_hv,
    input  logic             msr_pr,
    input  logic             hdec_ctl_en,
    input  logic             ext_edge_mode,
    input  logic             crit_edge_mode,
    output logic [N_SRC-1:0] enable,
    output logic [N_SRC-1:0] keep
);
    // Per-source enable: ungated, machine-check, hypervisor, critical or normal group.
    always_comb begin
        enable = '0;
        for (int k = 0; k < N_SRC; k++) begin
            if (k == SRC_RESET || k == SRC_DBG)
                enable[k] = 1'b1;
            else if (k == SRC_MCHK)
                enable[k] = msr_me;
            else if (k == SRC_HDEC)
                enable[k] = hdec_ctl_en & (msr_ee | ~msr_hv | msr_pr);
            else if (k >= SRC_CEXT && k <= SRC_CDB)
                enable[k] = msr_ce;
            else
                enable[k] = msr_ee;
        end
    end

    // Level-sensitive sources keep their flag after delivery.
    always_comb begin
        keep = '0;
        keep[SRC_EXT]  = ~ext_edge_mode;
        keep[SRC_CEXT] = ~crit_edge_mode;
    end
endmodule

// File: rtl/irq_arb_pend.sv
// Pending-flag bank.
// Holds one flag per source. A set pulse always wins over a clear in the
// same cycle, so no request is lost. Assumes clr is only asserted for
// flags the arbiter has just delivered.
module irq_arb_pend #(
    parameter int N_SRC = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] set,
    input  logic [N_SRC-1:0] clr,
    output logic [N_SRC-1:0] pend
);
    for (genvar g = 0; g < N_SRC; g++) begin : g_flag
        // One flag: reset low, set dominates clear.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pend[g] <= 1'b0;
            else if (set[g])
                pend[g] <= 1'b1;
            else if (clr[g])
                pend[g] <= 1'b0;
        end
    end

    // R9: every set pulse leaves its flag pending on the next cycle.
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        (|set) |=> ((pend & $past(set)) == $past(set)));
endmodule

// File: rtl/irq_arb_pick.sv
// Fixed-priority picker.
// Selects the lowest-indexed eligible source as a one-hot grant and its
// binary code. Pure combinational; assumes index 0 is highest priority.
module irq_arb_pick #(
    parameter int N_SRC  = 14,
    parameter int CODE_W = $clog2(N_SRC)
) (
    input  logic [N_SRC-1:0]  elig,
    output logic [N_SRC-1:0]  grant,
    output logic [CODE_W-1:0] code,
    output logic              any
);
    logic [N_SRC:0] below;

    assign below[0] = 1'b0;
    for (genvar g = 0; g < N_SRC; g++) begin : g_chain
        assign below[g+1] = below[g] | elig[g];
        assign grant[g]   = elig[g] & ~below[g];
    end
    assign any = below[N_SRC];

    // Encode the one-hot grant into a code.
    always_comb begin
        code = '0;
        for (int k = 0; k < N_SRC; k++)
            if (grant[k]) code = code | CODE_W'(k);
    end
endmodule

// File: rtl/irq_arb_top.sv
// Fixed-priority interrupt arbiter, top level.
// Masks pending flags with the state enables, and when no delivery is
// outstanding registers the winning code with a valid strobe, then clears
// the winner's flag unless it is level-sensitive. Holds the delivery until
// take_ack; assumes take_ack is only meaningful while irq_valid is high.
module irq_arb_top
    import irq_arb_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  req_set,
    input  logic                msr_me,
    input  logic                msr_ce,
    input  logic                msr_ee,
    input  logic                msr_hv,
    input  logic                msr_pr,
    input  logic                hdec_ctl_en,
    input  logic                ext_edge_mode,
    input  logic                crit_edge_mode,
    input  logic                take_ack,
    output logic                irq_valid,
    output logic [CODE_W-1:0]   irq_code
);
    logic [NUM_SRC-1:0] enable, keep, pend, elig, grant, clr;
    logic [CODE_W-1:0]  pick_code;
    logic               pick_any, fire;

    irq_arb_gate #(.N_SRC(NUM_SRC)) gate_i (
        .msr_me(msr_me), .msr_ce(msr_ce), .msr_ee(msr_ee),
        .msr_hv(msr_hv), .msr_pr(msr_pr), .hdec_ctl_en(hdec_ctl_en),
        .ext_edge_mode(ext_edge_mode), .crit_edge_mode(crit_edge_mode),
        .enable(enable), .keep(keep)
    );

    irq_arb_pend #(.N_SRC(NUM_SRC)) pend_i (
        .clk(clk), .rst_n(rst_n), .set(req_set), .clr(clr), .pend(pend)
    );

    irq_arb_pick #(.N_SRC(NUM_SRC), .CODE_W(CODE_W)) pick_i (
        .elig(elig), .grant(grant), .code(pick_code), .any(pick_any)
    );

    // Eligible sources, delivery decision and the clear it causes.
    assign elig = pend & enable;
    assign fire = ~irq_valid & pick_any;
    assign clr  = fire ? (grant & ~keep) : '0;

    // Delivery register: load on fire, drop on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_valid <= 1'b0;
            irq_code  <= '0;
        end else if (fire) begin
            irq_valid <= 1'b1;
            irq_code  <= pick_code;
        end else if (irq_valid && take_ack) begin
            irq_valid <= 1'b0;
        end
    end

    // R10: an unacknowledged delivery is held unchanged.
    a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && !take_ack) |=> (irq_valid && $stable(irq_code)));
    // R10: an acknowledged delivery is withdrawn on the next edge.
    a_r10_drop: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_valid && take_ack) |=> !irq_valid);
    // R3: machine check only delivered with its enable set.
    a_r3_mchk_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_valid) && irq_code == CODE_W'(SRC_MCHK)) |-> $past(msr_me));
    // R6: normal-group codes only delivered with external enable set.
    a_r6_norm_gate: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_valid) && irq_code >= CODE_W'(SRC_FIT)) |-> $past(msr_ee));
    // R8: a level-sensitive external source stays pending after delivery.
    a_r8_level_keep: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_valid) && irq_code == CODE_W'(SRC_EXT) && !$past(ext_edge_mode))
        |-> pend[SRC_EXT]);
endmodule

// File: tb/irq_arb_top_tb_top.sv
module irq_arb_top_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [13:0] req_set = '0;
    logic        msr_me = 1'b1, msr_ce = 1'b1, msr_ee = 1'b1;
    logic        msr_hv = 1'b0, msr_pr = 1'b0, hdec_ctl_en = 1'b1;
    logic        ext_edge_mode = 1'b1, crit_edge_mode = 1'b1;
    logic        take_ack = 1'b0;
    logic        irq_valid;
    logic [3:0]  irq_code;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #4 clk = ~clk;

    irq_arb_top dut_i (
        .clk(clk), .rst_n(rst_n), .req_set(req_set),
        .msr_me(msr_me), .msr_ce(msr_ce), .msr_ee(msr_ee),
        .msr_hv(msr_hv), .msr_pr(msr_pr), .hdec_ctl_en(hdec_ctl_en),
        .ext_edge_mode(ext_edge_mode), .crit_edge_mode(crit_edge_mode),
        .take_ack(take_ack), .irq_valid(irq_valid), .irq_code(irq_code)
    );

    task automatic step(int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic check(string req, logic exp_v, logic [3:0] exp_c);
        n_tests++;
        if (irq_valid !== exp_v || (exp_v && irq_code !== exp_c)) begin
            n_fail++;
            $display("FAIL %s: valid=%0b code=%0d expected valid=%0b code=%0d",
                     req, irq_valid, irq_code, exp_v, exp_c);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        req_set = '0;
        take_ack = 1'b0;
        step(1);
        rst_n = 1'b1;
    endtask

    task automatic pulse(logic [13:0] m);
        req_set = m;
        step(1);
        req_set = '0;
    endtask

    task automatic ack();
        take_ack = 1'b1;
        step(1);
        take_ack = 1'b0;
    endtask

    function automatic bit allowed(int s, bit me, bit ce, bit ee, bit hv, bit pr, bit hd);
        if (s == 0 || s == 2) return 1'b1;
        if (s == 1) return me;
        if (s == 3) return hd && (ee || !hv || pr);
        if (s >= 4 && s <= 6) return ce;
        return ee;
    endfunction

    initial begin
        @(negedge clk);
        do_reset();
        // R2: reset state
        check("R2", 1'b0, 4'd0);
        step(3);
        check("R2", 1'b0, 4'd0);

        // R1, R7: every ordered pair, one delivery per evaluation
        for (int i = 0; i < 14; i++) begin
            for (int j = i + 1; j < 14; j++) begin
                do_reset();
                pulse(14'(1 << i) | 14'(1 << j));
                step(1);
                check("R1", 1'b1, 4'(i));
                ack();
                step(1);
                check("R1", 1'b1, 4'(j));
                ack();
                step(1);
                check("R7", 1'b0, 4'd0);
            end
        end

        // R3 R4 R5 R6: each source against every enable combination
        for (int s = 0; s < 14; s++) begin
            for (int c = 0; c < 64; c++) begin
                bit exp;
                do_reset();
                {msr_me, msr_ce, msr_ee, msr_hv, msr_pr, hdec_ctl_en} = 6'(c);
                exp = allowed(s, c[5], c[4], c[3], c[2], c[1], c[0]);
                pulse(14'(1 << s));
                step(1);
                if (s == 1)      check("R3", exp, 4'(s));
                else if (s == 3) check("R4", exp, 4'(s));
                else if (s < 7)  check("R5", exp, 4'(s));
                else             check("R6", exp, 4'(s));
                if (exp) ack();
            end
        end
        {msr_me, msr_ce, msr_ee, msr_hv, msr_pr, hdec_ctl_en} = 6'b111001;

        // R11: masked request waits, then delivers one edge after enable
        do_reset();
        msr_ee = 1'b0;
        pulse(14'(1 << 9));
        step(3);
        check("R11", 1'b0, 4'd0);
        msr_ee = 1'b1;
        step(1);
        check("R11", 1'b1, 4'd9);
        ack();

        // R8: level-sensitive external and critical external re-deliver
        do_reset();
        ext_edge_mode = 1'b0;
        pulse(14'(1 << 10));
        step(1);
        check("R8", 1'b1, 4'd10);
        ack();
        step(1);
        check("R8", 1'b1, 4'd10);
        ext_edge_mode = 1'b1;
        ack();
        step(1);
        check("R8", 1'b1, 4'd10);
        ack();
        step(1);
        check("R8", 1'b0, 4'd0);
        do_reset();
        crit_edge_mode = 1'b0;
        pulse(14'(1 << 4));
        step(1);
        check("R8", 1'b1, 4'd4);
        ack();
        step(1);
        check("R8", 1'b1, 4'd4);
        crit_edge_mode = 1'b1;
        ack();
        step(1);
        check("R8", 1'b1, 4'd4);
        ack();
        step(1);
        check("R8", 1'b0, 4'd0);

        // R9: set pulse on the delivery edge survives the clear
        do_reset();
        pulse(14'(1 << 9));
        pulse(14'(1 << 9));
        check("R9", 1'b1, 4'd9);
        ack();
        step(1);
        check("R9", 1'b1, 4'd9);
        ack();
        step(1);
        check("R9", 1'b0, 4'd0);

        // R10: held without ack even when a higher source arrives
        do_reset();
        pulse(14'(1 << 9));
        step(1);
        check("R10", 1'b1, 4'd9);
        pulse(14'(1 << 0));
        step(3);
        check("R10", 1'b1, 4'd9);
        ack();
        check("R10", 1'b0, 4'd0);
        step(1);
        check("R10", 1'b1, 4'd0);
        ack();

        done = 1'b1;
    end

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not complete, expected completion");
        end
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule